// File: doc/BRIEF.md
# Descriptor Release Ring Router

This block sits where released buffer pointers and descriptor pointers come back from several producer modules. Each offered entry carries an address, a return-manager code, a software cookie, a source-module code and a buffer/descriptor type. The block checks whether the type agrees with the idle list that the return-manager code selects. Consistent entries are written into a circular normal ring. Inconsistent entries are flagged and written into a separate error ring.

Every ring slot is one 256-bit record of eight 32-bit words. Entries in the normal ring carry a 4-bit lap stamp, so a consumer can tell fresh slots from stale ones by looking at the stamp's lowest bit, without reading the write pointer. Entries in the error ring carry an error code in the same field instead. Each ring has its own write pointer, published as an output, and its own consumer read pointer, taken as an input. A ring counts as full when advancing its write pointer would make it equal to the read pointer. While the ring an entry targets is full, that entry is held off.

Top module: `rr_release_router`

## Requirements
- R1: Record layout. Word 0 (bits [31:0]) holds the low address. Word 1 holds the high address in [39:32], the return-manager code in [43:40] and the cookie in [63:44]. Word 2 holds the source code in [66:64], the type in [72:70] and the error flag in bit 95. The stamp or error code occupies bits [255:252].
- R2: Every other bit of a record is zero. This covers words 3 to 6, bits [69:67], bits [94:73] and bits [251:224].
- R3: An entry whose type is 0 (plain buffer) and whose return-manager code is 1, 2, 3 or 12 (link idle lists) goes to the error ring. Its flag is 1 and its code is 1.
- R4: An entry whose type is 1, 2 or 4 (link-style descriptor) and whose return-manager code is 0 (buffer idle list) goes to the error ring. Its flag is 1 and its code is 2.
- R5: All other entries go to the normal ring with the flag at 0. This includes type 3 (forwarded to firmware), any type with a return-manager code of 4 to 11 or 13 to 15, and consistent pairs.
- R6: An entry is accepted on a clock edge where in_valid and in_ready are both high. The write strobe of its ring rises for exactly one cycle after that edge, with the slot index equal to the ring's write pointer before acceptance. The write pointer then advances by one, modulo the depth.
- R7: Normal-ring entries written during the first pass carry stamp 1. The stamp goes up by one each time the normal write pointer wraps to 0, and after 15 it continues at 0.
- R8: in_ready is low when the target ring's write pointer plus one equals its read pointer. While it is low, nothing is written and no pointer moves.
- R9: The two rings use independent pointers. A write to one ring never moves the other ring's pointer, and one ring being full does not block entries bound for the other.
- R10: After reset both write pointers are 0, neither write strobe is high, and an entry with both read pointers at 0 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Entry offered |
| in_ready | output | 1 | Target ring can take the entry |
| in_addr_lo | input | 32 | Address bits 31..0 |
| in_addr_hi | input | 8 | Address bits 39..32 |
| in_ret_mgr | input | 4 | Return-manager code |
| in_cookie | input | 20 | Software cookie |
| in_src | input | 3 | Releasing source-module code |
| in_type | input | 3 | Buffer/descriptor type |
| norm_rd_ptr | input | AW | Consumer read pointer, normal ring |
| err_rd_ptr | input | AW | Consumer read pointer, error ring |
| norm_wr_ptr | output | AW | Write pointer, normal ring |
| err_wr_ptr | output | AW | Write pointer, error ring |
| norm_we | output | 1 | Normal-ring slot write strobe |
| norm_idx | output | AW | Normal-ring slot index |
| norm_data | output | 256 | Normal-ring record |
| err_we | output | 1 | Error-ring slot write strobe |
| err_idx | output | AW | Error-ring slot index |
| err_data | output | 256 | Error-ring record |

## Verification
Some properties are checked by assertions on every cycle. A write never lands in a full ring, and each ring's pointer moves by exactly one on a push and holds otherwise. Error-ring records always have the flag set and a nonzero code, while normal-ring records have the flag clear and words 3 to 6 at zero. Other properties can only be shown by the bench's scenarios: the exact pairing of type and return-manager code behind each routing decision, the lap stamp's progress through sixteen wraps back to 0, and one ring staying open while the other is held full.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int WORD_W  = 32;
  localparam int WORDS   = 8;
  localparam int ENTRY_W = WORD_W * WORDS;
  localparam int CNT_W   = 4;

  typedef enum logic [CNT_W-1:0] {
    RR_ERR_NONE        = 4'd0,
    RR_ERR_BUF_AS_LINK = 4'd1,
    RR_ERR_LINK_AS_BUF = 4'd2
  } rr_err_e;

  typedef struct packed {
    logic [31:0] addr_lo;
    logic [7:0]  addr_hi;
    logic [3:0]  ret_mgr;
    logic [19:0] cookie;
    logic [2:0]  src;
    logic [2:0]  dtype;
  } rr_desc_t;
endpackage

// File: rtl/rr_rst_sync.sv
module rr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/rr_classify.sv
module rr_classify
  import rr_pkg::*;
(
  input  logic [3:0]       ret_mgr,
  input  logic [2:0]       dtype,
  output logic             is_err,
  output logic [CNT_W-1:0] err_code
);
  logic to_link_list, to_buf_list, is_buf, is_link;

  always_comb begin
    to_buf_list  = (ret_mgr == 4'd0);
    to_link_list = (ret_mgr inside {4'd1, 4'd2, 4'd3, 4'd12});
    is_buf       = (dtype == 3'd0);
    is_link      = (dtype inside {3'd1, 3'd2, 3'd4});
    err_code     = RR_ERR_NONE;
    if (is_buf && to_link_list)      err_code = RR_ERR_BUF_AS_LINK;
    else if (is_link && to_buf_list) err_code = RR_ERR_LINK_AS_BUF;
    is_err = (err_code != RR_ERR_NONE);
  end
endmodule

// File: rtl/rr_entry_pack.sv
module rr_entry_pack
  import rr_pkg::*;
(
  input  rr_desc_t           desc,
  input  logic               err_flag,
  input  logic [CNT_W-1:0]   cnt,
  output logic [ENTRY_W-1:0] entry
);
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    if (i == 0) begin : g_addr
      assign entry[i*WORD_W +: WORD_W] = desc.addr_lo;
    end else if (i == 1) begin : g_mgr
      assign entry[i*WORD_W +: WORD_W] = {desc.cookie, desc.ret_mgr, desc.addr_hi};
    end else if (i == 2) begin : g_info
      assign entry[i*WORD_W +: WORD_W] = {err_flag, 22'd0, desc.dtype, 3'd0, desc.src};
    end else if (i == WORDS - 1) begin : g_cnt
      assign entry[i*WORD_W +: WORD_W] = {cnt, {(WORD_W-CNT_W){1'b0}}};
    end else begin : g_zero
      assign entry[i*WORD_W +: WORD_W] = '0;
    end
  end
endmodule

// File: rtl/rr_ring_ptr.sv
module rr_ring_ptr #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] wr_ptr,
  output logic          full,
  output logic          wrap
);
  logic [AW-1:0] wr_q, wr_d, wr_inc;

  always_comb begin
    wr_inc = AW'(wr_q + 1'b1);
    full   = (wr_inc == rd_ptr);
    wrap   = push && (wr_q == {AW{1'b1}});
    wr_d   = push ? wr_inc : wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= '0;
    else        wr_q <= wr_d;
  end

  assign wr_ptr = wr_q;

  // R8
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (AW'(wr_ptr + 1'b1) != rd_ptr));
  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (wr_ptr == AW'($past(wr_ptr) + 1'b1)));
  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(wr_ptr));
endmodule

// File: rtl/rr_release_router.sv
module rr_release_router
  import rr_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_addr_lo,
  input  logic [7:0]         in_addr_hi,
  input  logic [3:0]         in_ret_mgr,
  input  logic [19:0]        in_cookie,
  input  logic [2:0]         in_src,
  input  logic [2:0]         in_type,
  input  logic [AW-1:0]      norm_rd_ptr,
  input  logic [AW-1:0]      err_rd_ptr,
  output logic [AW-1:0]      norm_wr_ptr,
  output logic [AW-1:0]      err_wr_ptr,
  output logic               norm_we,
  output logic [AW-1:0]      norm_idx,
  output logic [ENTRY_W-1:0] norm_data,
  output logic               err_we,
  output logic [AW-1:0]      err_idx,
  output logic [ENTRY_W-1:0] err_data
);
  logic               srst_n;
  rr_desc_t           desc;
  logic               is_err, norm_full, err_full, norm_wrap, err_wrap;
  logic               accept, norm_push, err_push;
  logic [CNT_W-1:0]   err_code, stamp;
  logic [CNT_W-1:0]   lap_q, lap_d;
  logic [ENTRY_W-1:0] entry;
  logic               nwe_q, nwe_d, ewe_q, ewe_d;
  logic [AW-1:0]      nidx_q, nidx_d, eidx_q, eidx_d;
  logic [ENTRY_W-1:0] ndat_q, ndat_d, edat_q, edat_d;

  rr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  assign desc = '{addr_lo: in_addr_lo, addr_hi: in_addr_hi, ret_mgr: in_ret_mgr,
                  cookie: in_cookie, src: in_src, dtype: in_type};

  rr_classify u_cls (.ret_mgr(in_ret_mgr), .dtype(in_type), .is_err(is_err), .err_code(err_code));

  rr_ring_ptr #(.AW(AW)) u_nptr (.clk(clk), .rst_n(srst_n), .push(norm_push), .rd_ptr(norm_rd_ptr),
                                 .wr_ptr(norm_wr_ptr), .full(norm_full), .wrap(norm_wrap));
  rr_ring_ptr #(.AW(AW)) u_eptr (.clk(clk), .rst_n(srst_n), .push(err_push), .rd_ptr(err_rd_ptr),
                                 .wr_ptr(err_wr_ptr), .full(err_full), .wrap(err_wrap));

  rr_entry_pack u_pack (.desc(desc), .err_flag(is_err), .cnt(stamp), .entry(entry));

  always_comb begin
    in_ready  = is_err ? !err_full : !norm_full;
    accept    = in_valid && in_ready;
    norm_push = accept && !is_err;
    err_push  = accept && is_err;
    stamp     = is_err ? err_code : CNT_W'(lap_q + 1'b1);
    lap_d     = norm_wrap ? CNT_W'(lap_q + 1'b1) : lap_q;
    nwe_d     = norm_push;
    nidx_d    = norm_push ? norm_wr_ptr : nidx_q;
    ndat_d    = norm_push ? entry : ndat_q;
    ewe_d     = err_push;
    eidx_d    = err_push ? err_wr_ptr : eidx_q;
    edat_d    = err_push ? entry : edat_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      lap_q  <= '0;
      nwe_q  <= 1'b0;
      nidx_q <= '0;
      ndat_q <= '0;
      ewe_q  <= 1'b0;
      eidx_q <= '0;
      edat_q <= '0;
    end else begin
      lap_q  <= lap_d;
      nwe_q  <= nwe_d;
      nidx_q <= nidx_d;
      ndat_q <= ndat_d;
      ewe_q  <= ewe_d;
      eidx_q <= eidx_d;
      edat_q <= edat_d;
    end
  end

  assign norm_we   = nwe_q;
  assign norm_idx  = nidx_q;
  assign norm_data = ndat_q;
  assign err_we    = ewe_q;
  assign err_idx   = eidx_q;
  assign err_data  = edat_q;

  // R3
  err_rec_flag_chk: assert property (@(posedge clk) disable iff (!srst_n)
    err_we |-> (err_data[95] && (err_data[255:252] != 4'd0)));
  // R5
  norm_rec_flag_chk: assert property (@(posedge clk) disable iff (!srst_n)
    norm_we |-> !norm_data[95]);
  // R2
  norm_zero_words_chk: assert property (@(posedge clk) disable iff (!srst_n)
    norm_we |-> (norm_data[223:96] == '0));
  // R6
  norm_idx_chk: assert property (@(posedge clk) disable iff (!srst_n)
    norm_we |-> (norm_wr_ptr == AW'(norm_idx + 1'b1)));
endmodule

// File: tb/rr_release_router_tb_top.sv
module rr_release_router_tb_top;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [31:0]  in_addr_lo;
  logic [7:0]   in_addr_hi;
  logic [3:0]   in_ret_mgr;
  logic [19:0]  in_cookie;
  logic [2:0]   in_src;
  logic [2:0]   in_type;
  logic [2:0]   norm_rd_ptr, err_rd_ptr, norm_wr_ptr, err_wr_ptr, norm_idx, err_idx;
  logic         norm_we, err_we;
  logic [255:0] norm_data, err_data;

  int n_chk = 0;
  int n_fail = 0;
  int nptr = 0, eptr = 0, nlap = 0;
  logic         x_nwe, x_ewe;
  int           x_nidx, x_eidx;
  logic [255:0] x_ndat, x_edat;

  always #10 clk = ~clk;

  rr_release_router #(.DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr_lo(in_addr_lo), .in_addr_hi(in_addr_hi), .in_ret_mgr(in_ret_mgr),
    .in_cookie(in_cookie), .in_src(in_src), .in_type(in_type),
    .norm_rd_ptr(norm_rd_ptr), .err_rd_ptr(err_rd_ptr),
    .norm_wr_ptr(norm_wr_ptr), .err_wr_ptr(err_wr_ptr),
    .norm_we(norm_we), .norm_idx(norm_idx), .norm_data(norm_data),
    .err_we(err_we), .err_idx(err_idx), .err_data(err_data));

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] rec(input logic [31:0] lo, input logic [7:0] hi,
      input logic [3:0] rm, input logic [19:0] ck, input logic [2:0] s,
      input logic [2:0] t, input logic e, input logic [3:0] c);
    logic [255:0] r = '0;
    r[31:0] = lo; r[39:32] = hi; r[43:40] = rm; r[63:44] = ck;
    r[66:64] = s; r[72:70] = t; r[95] = e; r[255:252] = c;
    return r;
  endfunction

  // R3 / R4 / R5 classification from the requirement text
  function automatic int code_of(input logic [3:0] rm, input logic [2:0] t);
    if (t == 3'd0 && (rm == 4'd1 || rm == 4'd2 || rm == 4'd3 || rm == 4'd12)) return 1;
    if ((t == 3'd1 || t == 3'd2 || t == 3'd4) && rm == 4'd0) return 2;
    return 0;
  endfunction

  task automatic set_in(input logic v, input logic [31:0] lo, input logic [7:0] hi,
      input logic [3:0] rm, input logic [19:0] ck, input logic [2:0] s, input logic [2:0] t);
    in_valid = v; in_addr_lo = lo; in_addr_hi = hi; in_ret_mgr = rm;
    in_cookie = ck; in_src = s; in_type = t;
  endtask

  // one clock: check ready, predict, cross the edge, compare outputs
  task automatic step(input string tag);
    int  c;
    logic er, rdy, acc;
    #3;
    c   = code_of(in_ret_mgr, in_type);
    er  = (c != 0);
    rdy = er ? (((eptr + 1) % D) != err_rd_ptr) : (((nptr + 1) % D) != norm_rd_ptr);
    chk({tag, " R8 ready"}, 256'(in_ready), 256'(rdy));
    acc = in_valid && rdy;
    x_nwe = acc && !er;
    x_ewe = acc && er;
    if (x_nwe) begin
      x_nidx = nptr;
      x_ndat = rec(in_addr_lo, in_addr_hi, in_ret_mgr, in_cookie, in_src, in_type, 1'b0, 4'((nlap + 1) % 16));
      if (nptr == D - 1) nlap = (nlap + 1) % 16;
      nptr = (nptr + 1) % D;
    end
    if (x_ewe) begin
      x_eidx = eptr;
      x_edat = rec(in_addr_lo, in_addr_hi, in_ret_mgr, in_cookie, in_src, in_type, 1'b1, 4'(c));
      eptr = (eptr + 1) % D;
    end
    @(posedge clk);
    #2;
    chk({tag, " R6 norm_we"}, 256'(norm_we), 256'(x_nwe));
    chk({tag, " R6 err_we"}, 256'(err_we), 256'(x_ewe));
    chk({tag, " R9 norm_wr_ptr"}, 256'(norm_wr_ptr), 256'(nptr));
    chk({tag, " R9 err_wr_ptr"}, 256'(err_wr_ptr), 256'(eptr));
    if (x_nwe) begin
      chk({tag, " R6 norm_idx"}, 256'(norm_idx), 256'(x_nidx));
      chk({tag, " R1 R2 R7 norm_data"}, norm_data, x_ndat);
    end
    if (x_ewe) begin
      chk({tag, " R6 err_idx"}, 256'(err_idx), 256'(x_eidx));
      chk({tag, " R3 R4 err_data"}, err_data, x_edat);
    end
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    norm_rd_ptr = '0; err_rd_ptr = '0;
    set_in(1'b0, 32'd0, 8'd0, 4'd0, 20'd0, 3'd0, 3'd0);
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    chk("R10 norm_wr_ptr", 256'(norm_wr_ptr), 256'(0));
    chk("R10 err_wr_ptr", 256'(err_wr_ptr), 256'(0));
    chk("R10 norm_we", 256'(norm_we), 256'(0));
    chk("R10 err_we", 256'(err_we), 256'(0));
    chk("R10 ready", 256'(in_ready), 256'(1));

    // R1 R5: assorted consistent entries
    set_in(1'b1, 32'hDEAD_BEEF, 8'hA5, 4'd0, 20'hABCDE, 3'd1, 3'd0); step("R5 buf->buflist");
    set_in(1'b1, 32'h1234_5678, 8'h3C, 4'd2, 20'h00F0F, 3'd2, 3'd1); step("R5 link->linklist");
    set_in(1'b1, 32'hFFFF_0000, 8'hFF, 4'd0, 20'hFFFFF, 3'd7, 3'd3); step("R5 ext->fw");
    set_in(1'b1, 32'h0000_0001, 8'h01, 4'd7, 20'h12345, 3'd4, 3'd1); step("R5 sw ring");
    set_in(1'b1, 32'h8000_0000, 8'h80, 4'd4, 20'h80000, 3'd5, 3'd0); step("R5 fw mgr");
    set_in(1'b1, 32'h0F0F_0F0F, 8'h0F, 4'd12, 20'h55555, 3'd2, 3'd4); step("R5 qext->link");
    set_in(1'b0, 32'h0, 8'h0, 4'd0, 20'h0, 3'd0, 3'd0); step("R6 idle");

    // R3 / R4 error routing
    set_in(1'b1, 32'hCAFE_0001, 8'h11, 4'd1, 20'h11111, 3'd2, 3'd0); step("R3 mgr1");
    set_in(1'b1, 32'hCAFE_0002, 8'h22, 4'd12, 20'h22222, 3'd5, 3'd0); step("R3 mgr12");
    set_in(1'b1, 32'hCAFE_0003, 8'h33, 4'd0, 20'h33333, 3'd1, 3'd1); step("R4 type1");
    set_in(1'b1, 32'hCAFE_0004, 8'h44, 4'd0, 20'h44444, 3'd4, 3'd2); step("R4 type2");
    set_in(1'b1, 32'hCAFE_0005, 8'h55, 4'd0, 20'h55555, 3'd6, 3'd4); step("R4 type4");

    // R8 / R9: normal ring full, error ring still open
    norm_rd_ptr = 3'((nptr + 1) % D);
    set_in(1'b1, 32'hB10C_0001, 8'h01, 4'd5, 20'h0BEEF, 3'd1, 3'd0); step("R8 norm full");
    step("R8 norm full hold");
    set_in(1'b1, 32'hB10C_0002, 8'h02, 4'd3, 20'h0FACE, 3'd2, 3'd0); step("R9 err while norm full");
    norm_rd_ptr = 3'(nptr);
    set_in(1'b1, 32'hB10C_0003, 8'h03, 4'd5, 20'h0BEEF, 3'd1, 3'd0); step("R8 norm released");
    err_rd_ptr = 3'((eptr + 1) % D);
    set_in(1'b1, 32'hB10C_0004, 8'h04, 4'd0, 20'h01234, 3'd1, 3'd2); step("R8 err full");
    set_in(1'b1, 32'hB10C_0005, 8'h05, 4'd9, 20'h04321, 3'd1, 3'd2); step("R9 norm while err full");
    err_rd_ptr = 3'(eptr);
    set_in(1'b1, 32'hB10C_0006, 8'h06, 4'd0, 20'h01234, 3'd1, 3'd2); step("R8 err released");

    // R7: stream through 17 laps so the stamp wraps from 15 to 0
    for (int i = 0; i < 17 * D; i++) begin
      norm_rd_ptr = 3'(nptr);
      set_in(1'b1, 32'(i * 32'h0101_0101), 8'(i), 4'(5 + (i % 7)), 20'(i * 7), 3'(i % 7), 3'(i % 5));
      step("R7 lap stream");
    end
    set_in(1'b0, 32'h0, 8'h0, 4'd0, 20'h0, 3'd0, 3'd0); step("R6 final idle");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule